// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a row of identical two-stage boundary cells that sits between device pins and the core logic. Every cell holds a capture/shift flop and a separate update stage. A shared control decode tells all cells, on a data-register clock enable, either to load their parallel input or to take the bit from the cell upstream. The chain therefore forms one serial path from `scan_in` to `scan_out`. An update strobe copies every shift flop into its update stage at the same moment. A mode input then selects, for each pin, either the live parallel input (normal operation) or the held update value (test operation).

The same cell works on the input side of the core or on the output side. The strobes normally come from a test access controller, but here they are plain inputs. The update stage is isolated from the shift flop, so a new pattern can be shifted through while the pins keep the previous pattern. Capture and update may share one cycle. In that cycle the old stimulus is applied while responses are sampled, which supports at-speed delay checks.

Top module: `bscan_chain`

## Requirements
- R1: After reset every shift flop and every update stage is 0, so `scan_out` is 0 and, with `test_mode`=1, `pin_out` is all zeros.
- R2: With `test_mode`=0, `pin_out[i]` equals `pin_in[i]` combinationally for every cell, whatever the update stages hold.
- R3: With `test_mode`=1, `pin_out[i]` equals the update stage of cell i.
- R4: A clock edge with `dr_clk_en`=1 and `dr_shift`=0 loads `pin_in[i]` into the shift flop of every cell i.
- R5: A clock edge with `dr_clk_en`=1 and `dr_shift`=1 moves each shift flop value one cell toward the output end. Cell 0 takes `scan_in`, and `scan_out` is always the shift flop of cell CELLS-1.
- R6: After exactly CELLS shift pulses, the first bit shifted in sits in cell CELLS-1. It is the first bit to appear on `scan_out` and drives `pin_out[CELLS-1]` after an update.
- R7: Capture and shift pulses never change the update stages. In test mode `pin_out` keeps its value until the next update strobe.
- R8: On an edge with `dr_clk_en`=0 the shift flops hold, even when `dr_shift` is 1.
- R9: An edge with `dr_update`=1 copies all shift flops into their update stages at once. Without that strobe the update stages hold.
- R10: When capture and update occur on the same edge, the update stages receive the shift flop values from before that edge, and the shift flops receive `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_clk_en | input | 1 | Data-register clock enable (one pulse per capture or shift) |
| dr_shift | input | 1 | 1 selects shift, 0 selects capture on an enabled edge |
| dr_update | input | 1 | Copy shift flops into update stages |
| test_mode | input | 1 | 0 passes pins through, 1 drives pins from update stages |
| scan_in | input | 1 | Serial input into cell 0 |
| pin_in | input | CELLS | Parallel inputs, one per cell |
| pin_out | output | CELLS | Parallel outputs, one per cell |
| scan_out | output | 1 | Serial output from cell CELLS-1 |

## Verification
The bench builds the chain with CELLS=5. An odd length that differs from the default of 8 exposes any hard-wired chain length or bit-order slip. With five cells, a lone marker bit can be walked the whole length, and each intermediate `scan_out` value can be checked on every pulse. Patterns can also be read out completely in a few cycles, so capture-with-update collisions and shift-under-hold cases each take only a short directed task.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   // operation applied to every shift flop on a clock edge
   typedef enum logic [1:0] {
      OP_HOLD    = 2'd0,
      OP_CAPTURE = 2'd1,
      OP_SHIFT   = 2'd2
   } cell_op_e;

   function automatic cell_op_e bsc_decode(input logic clk_en, input logic shift);
      if (!clk_en)    return OP_HOLD;
      else if (shift) return OP_SHIFT;
      else            return OP_CAPTURE;
   endfunction

endpackage

// File: rtl/bsc_cell.sv
module bsc_cell
   import bsc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  cell_op_e op,
   input  logic     upd_en,
   input  logic     test_mode,
   input  logic     par_in,
   input  logic     ser_in,
   output logic     par_out,
   output logic     ser_out,
   output logic     hold_o
);

   logic shf_q;
   logic upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shf_q <= 1'b0;
      end else begin
         unique case (op)
            OP_CAPTURE: shf_q <= par_in;
            OP_SHIFT:   shf_q <= ser_in;
            default:    shf_q <= shf_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      upd_q <= 1'b0;
      else if (upd_en) upd_q <= shf_q;
   end

   assign par_out = test_mode ? upd_q : par_in;
   assign ser_out = shf_q;
   assign hold_o  = upd_q;

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
   import bsc_pkg::*;
#(
   parameter int CELLS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dr_clk_en,
   input  logic             dr_shift,
   input  logic             dr_update,
   input  logic             test_mode,
   input  logic             scan_in,
   input  logic [CELLS-1:0] pin_in,
   output logic [CELLS-1:0] pin_out,
   output logic             scan_out
);

   localparam int LAST = CELLS - 1;

   generate
      if (CELLS < 2) begin : g_bad_len
         $error("bscan_chain: CELLS must be at least 2");
      end
   endgenerate

   cell_op_e         op;
   logic [CELLS-1:0] cap_q;
   logic [CELLS-1:0] upd_q;
   logic [CELLS-1:0] ser_src;

   assign op = bsc_decode(dr_clk_en, dr_shift);

   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_cell
         if (i == 0) begin : g_head
            assign ser_src[i] = scan_in;
         end else begin : g_link
            assign ser_src[i] = cap_q[i-1];
         end

         bsc_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .op        (op),
            .upd_en    (dr_update),
            .test_mode (test_mode),
            .par_in    (pin_in[i]),
            .ser_in    (ser_src[i]),
            .par_out   (pin_out[i]),
            .ser_out   (cap_q[i]),
            .hold_o    (upd_q[i])
         );
      end
   endgenerate

   assign scan_out = cap_q[LAST];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
   parameter int CELLS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dr_clk_en,
   input logic             dr_shift,
   input logic             dr_update,
   input logic             test_mode,
   input logic             scan_in,
   input logic [CELLS-1:0] pin_in,
   input logic [CELLS-1:0] pin_out,
   input logic             scan_out,
   input logic [CELLS-1:0] cap_q,
   input logic [CELLS-1:0] upd_q
);

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> pin_out == pin_in); // R2

   AST_TEST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |-> pin_out == upd_q); // R3

   AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_clk_en && !dr_shift) |=> cap_q == $past(pin_in)); // R4

   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_clk_en && dr_shift) |=> cap_q == {$past(cap_q[CELLS-2:0]), $past(scan_in)}); // R5

   AST_SCAN_TAP: assert property (@(posedge clk) disable iff (!rst_n)
      scan_out == cap_q[CELLS-1]); // R5

   AST_UPD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !dr_update |=> $stable(upd_q)); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !dr_clk_en |=> $stable(cap_q)); // R8

   AST_UPD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      dr_update |=> upd_q == $past(cap_q)); // R9

endmodule

bind bscan_chain bscan_chain_chk #(.CELLS(CELLS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dr_clk_en (dr_clk_en),
   .dr_shift  (dr_shift),
   .dr_update (dr_update),
   .test_mode (test_mode),
   .scan_in   (scan_in),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .scan_out  (scan_out),
   .cap_q     (cap_q),
   .upd_q     (upd_q)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;

   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dr_clk_en = 1'b0;
   logic         dr_shift = 1'b0;
   logic         dr_update = 1'b0;
   logic         test_mode = 1'b0;
   logic         scan_in = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_out;
   logic         scan_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bscan_chain #(.CELLS(N)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .dr_clk_en (dr_clk_en),
      .dr_shift  (dr_shift),
      .dr_update (dr_update),
      .test_mode (test_mode),
      .scan_in   (scan_in),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .scan_out  (scan_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; drives controls for one rising edge, returns at next falling edge
   task automatic cyc(input logic en, input logic sh, input logic up, input logic si);
      dr_clk_en = en; dr_shift = sh; dr_update = up; scan_in = si;
      @(negedge clk);
      dr_clk_en = 1'b0; dr_shift = 1'b0; dr_update = 1'b0; scan_in = 1'b0;
   endtask

   // place v[i] into cell i: last cell's bit goes in first
   task automatic load_chain(input logic [N-1:0] v);
      for (int k = N - 1; k >= 0; k--) cyc(1'b1, 1'b1, 1'b0, v[k]);
   endtask

   // read all shift flops; scan_out shows the last cell first
   task automatic read_chain(output logic [N-1:0] v);
      for (int k = N - 1; k >= 0; k--) begin
         v[k] = scan_out;
         cyc(1'b1, 1'b1, 1'b0, 1'b0);
      end
   endtask

   task automatic t_reset;
      test_mode = 1'b1;
      #1;
      check("R1 pin_out after reset", pin_out, 0);
      check("R1 scan_out after reset", scan_out, 0);
      test_mode = 1'b0;
   endtask

   task automatic t_normal;
      logic [N-1:0] pats [4] = '{5'b00000, 5'b11111, 5'b10101, 5'b01110};
      test_mode = 1'b0;
      foreach (pats[j]) begin
         pin_in = pats[j]; #1;
         check("R2 pass-through", pin_out, pats[j]);
      end
      load_chain(5'b11011);
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      pin_in = 5'b00100; #1;
      check("R2 pass-through with loaded update stage", pin_out, 5'b00100);
      test_mode = 1'b1; #1;
      check("R3 test drive after update", pin_out, 5'b11011);
      test_mode = 1'b0;
   endtask

   task automatic t_walk;
      test_mode = 1'b0;
      load_chain('0);
      for (int k = 1; k <= N; k++) begin
         cyc(1'b1, 1'b1, 1'b0, k == 1);
         check("R5 marker position on scan_out", scan_out, (k == N));
      end
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      test_mode = 1'b1; #1;
      check("R6 first bit reaches last cell", pin_out, 1 << (N - 1));
      test_mode = 1'b0;
   endtask

   task automatic t_no_disturb;
      logic [N-1:0] rd;
      load_chain(5'b10011);
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      test_mode = 1'b1;
      for (int k = N - 1; k >= 0; k--) begin
         cyc(1'b1, 1'b1, 1'b0, k[0]);
         check("R7 pin_out held during shift", pin_out, 5'b10011);
      end
      pin_in = 5'b01100;
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      check("R7 pin_out held during capture", pin_out, 5'b10011);
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      check("R9 update applies new data", pin_out, 5'b01100);
      read_chain(rd);
      check("R7 pin_out held during readout", pin_out, 5'b01100);
      test_mode = 1'b0;
   endtask

   task automatic t_capture;
      logic [N-1:0] rd;
      pin_in = 5'b10110;
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      pin_in = 5'b00000;
      read_chain(rd);
      check("R4 captured pattern 10110", rd, 5'b10110);
      pin_in = 5'b01001;
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      pin_in = 5'b11111;
      read_chain(rd);
      check("R4 captured pattern 01001", rd, 5'b01001);
   endtask

   task automatic t_hold;
      logic [N-1:0] rd;
      load_chain(5'b11001);
      check("R8 scan_out before idle", scan_out, 1);
      for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
      check("R8 scan_out with shift but no enable", scan_out, 1);
      pin_in = 5'b00110;
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      read_chain(rd);
      check("R8 chain held without enable", rd, 5'b11001);
   endtask

   task automatic t_cap_upd;
      logic [N-1:0] rd;
      load_chain(5'b00111);
      pin_in = 5'b11010;
      test_mode = 1'b1;
      cyc(1'b1, 1'b0, 1'b1, 1'b0);
      check("R10 update takes pre-capture data", pin_out, 5'b00111);
      pin_in = 5'b00000;
      read_chain(rd);
      check("R10 capture took pin_in", rd, 5'b11010);
      check("R3 test drive after readout", pin_out, 5'b00111);
      test_mode = 1'b0;
   endtask

   initial begin
      #(20 * 5000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_normal();
      t_walk();
      t_no_disturb();
      t_capture();
      t_hold();
      t_cap_upd();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule